// File: doc/BRIEF.md
# Widening Unsigned Vector Multiply-Accumulate Unit

This unit performs one widening unsigned multiply-accumulate pass over a vector. Two source vectors carry elements of the selected width (8, 16 or 32 bits) and an accumulator vector carries elements of twice that width. For each element that takes part in the operation, the two source elements are multiplied at full double width and the product is added to the matching accumulator element. The sum wraps modulo 2 to the power of the double width.

Participation is set per element. The unit uses the start index, the element length and an optional per-element enable bit. Elements below the start index keep their old value. Elements at or past the length form the tail, and elements in the window whose enable bit is clear are masked off. Each of these two groups either keeps its old value or is filled with all ones, as its own policy bit selects. The unit is a sequencer that visits one element index per clock cycle, and a start/done handshake wraps each pass.

The controller has three states. IDLE waits for a start pulse. On start it takes the "accept" transition to RUN and latches every operand. RUN handles one element index per cycle: the "step" transition loops while indices remain, and the "finish" transition goes to DONE after the last index. DONE raises done for one cycle, then takes the "return" transition back to IDLE.

Top module: `wmac_unit`

## Requirements
- R1: For an active element i, the result is (a_i * b_i + acc_i) mod 2^(2*SEW). Here a_i and b_i are unsigned SEW-bit values and acc_i is the unsigned 2*SEW-bit old accumulator element.
- R2: width_sel 0, 1 and 2 select SEW = 8, 16 and 32. Code 3 acts as SEW = 32. Source element i occupies bits [i*SEW +: SEW] and accumulator element i occupies bits [i*2*SEW +: 2*SEW]. VLEN/SEW element indices are visited.
- R3: Element i is active when start_idx <= i < elem_len and either unmasked = 1 or elem_en[i] = 1. With unmasked = 1 the elem_en bits have no effect.
- R4: An element with i < start_idx keeps its old accumulator value whatever the policies and the length. This rule takes priority over the tail and mask rules.
- R5: An element with i >= elem_len and i >= start_idx (tail) keeps its old value when tail_agn = 0 and becomes all ones when tail_agn = 1.
- R6: An element in the window whose elem_en bit is 0 while unmasked = 0 keeps its old value when mask_agn = 0 and becomes all ones when mask_agn = 1.
- R7: The unit accepts a start pulse in IDLE, and busy is 1 in the following cycle. The pass takes one cycle per element index (VLEN/SEW indices). done is 1 for exactly one cycle, beginning VLEN/SEW clock edges after the edge that sampled start. In the cycle after that, busy and done are both 0.
- R8: A start pulse while busy is 1 (RUN or DONE) is ignored: the running pass finishes with its original operands and no new pass begins.
- R9: While done is 1, resume_idx reads 0. acc_out holds the result unchanged from done until the next accepted start.
- R10: After reset, busy, done, acc_out and resume_idx are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a pass (accepted only in IDLE) |
| width_sel | input | 2 | Element width code: 0=8, 1=16, 2 or 3=32 bits |
| elem_len | input | $clog2(VLEN/8)+1 | Number of elements in the operation |
| start_idx | input | $clog2(VLEN/8)+1 | First element index to compute |
| unmasked | input | 1 | 1: ignore elem_en; 0: elem_en gates elements |
| elem_en | input | VLEN/8 | Per-element enable bits, bit i for element i |
| tail_agn | input | 1 | Tail policy: 0 keep, 1 fill ones |
| mask_agn | input | 1 | Masked-off policy: 0 keep, 1 fill ones |
| src_a | input | VLEN | First multiplicand vector |
| src_b | input | VLEN | Second multiplicand vector |
| acc_in | input | 2*VLEN | Old accumulator vector |
| busy | output | 1 | High in RUN and DONE |
| done | output | 1 | One-cycle completion pulse |
| acc_out | output | 2*VLEN | Result accumulator vector |
| resume_idx | output | $clog2(VLEN/8)+1 | Start index in effect; 0 once the pass completes |

## Verification
Once start is sampled at a clock edge, busy is due on the following falling edge. done is due on the falling edge after edge number VLEN/SEW, and the return to idle is due one edge later. The bench drives inputs on falling edges and steps through the pass with a counted loop. It samples done only at the expected falling edge and flags any earlier rise, so a result that arrives one cycle early or late fails. The accumulator lanes and resume_idx are compared in the done cycle. They are compared again two idle cycles later to check that they hold, and a start pulse issued during the DONE cycle must leave busy low on the next falling edge.

// File: rtl/wmac_pkg.sv
package wmac_pkg;

    // Widest source element and its doubled accumulator element.
    localparam int MAX_SEW = 32;
    localparam int MAX_ACC = 2 * MAX_SEW;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } state_e;

    typedef enum logic [1:0] {
        CLS_ACTIVE   = 2'd0,
        CLS_PRESTART = 2'd1,
        CLS_TAIL     = 2'd2,
        CLS_MASKOFF  = 2'd3
    } elem_class_e;

    // log2(SEW/8): code 3 is folded onto the widest setting.
    function automatic logic [1:0] sew_shift(input logic [1:0] code);
        return (code == 2'd3) ? 2'd2 : code;
    endfunction

endpackage

// File: rtl/wmac_operand_sel.sv
module wmac_operand_sel
    import wmac_pkg::*;
#(
    parameter int VLEN = 64
) (
    input  logic [VLEN-1:0]              src_a,
    input  logic [VLEN-1:0]              src_b,
    input  logic [2*VLEN-1:0]            acc,
    input  logic [$clog2(VLEN/8)-1:0]    idx,
    input  logic [1:0]                   shift,
    output logic [MAX_SEW-1:0]           op_a,
    output logic [MAX_SEW-1:0]           op_b,
    output logic [MAX_ACC-1:0]           op_acc
);

    localparam int NW = 3;

    logic [MAX_SEW-1:0] a_w   [NW];
    logic [MAX_SEW-1:0] b_w   [NW];
    logic [MAX_ACC-1:0] acc_w [NW];

    // One lane extractor per supported element width.
    for (genvar g = 0; g < NW; g++) begin : g_width
        localparam int W = 8 << g;
        logic [VLEN-1:0]   a_sh;
        logic [VLEN-1:0]   b_sh;
        logic [2*VLEN-1:0] acc_sh;

        assign a_sh    = src_a >> (idx * W);
        assign b_sh    = src_b >> (idx * W);
        assign acc_sh  = acc >> (idx * 2 * W);
        assign a_w[g]   = MAX_SEW'(a_sh[W-1:0]);
        assign b_w[g]   = MAX_SEW'(b_sh[W-1:0]);
        assign acc_w[g] = MAX_ACC'(acc_sh[2*W-1:0]);
    end

    always_comb begin
        unique case (shift)
            2'd0: begin
                op_a   = a_w[0];
                op_b   = b_w[0];
                op_acc = acc_w[0];
            end
            2'd1: begin
                op_a   = a_w[1];
                op_b   = b_w[1];
                op_acc = acc_w[1];
            end
            default: begin
                op_a   = a_w[2];
                op_b   = b_w[2];
                op_acc = acc_w[2];
            end
        endcase
    end

endmodule

// File: rtl/wmac_mac.sv
module wmac_mac
    import wmac_pkg::*;
(
    input  logic [MAX_SEW-1:0] op_a,
    input  logic [MAX_SEW-1:0] op_b,
    input  logic [MAX_ACC-1:0] op_acc,
    input  logic [1:0]         shift,
    output logic [MAX_ACC-1:0] sum
);

    localparam int NW = 3;

    logic [MAX_ACC-1:0] sum_w [NW];

    // Exact double-width product, then a wrapping add at that width.
    for (genvar g = 0; g < NW; g++) begin : g_width
        localparam int W = 8 << g;
        logic [2*W-1:0] prod;
        logic [2*W-1:0] total;

        assign prod     = (2*W)'(op_a[W-1:0]) * (2*W)'(op_b[W-1:0]);
        assign total    = prod + op_acc[2*W-1:0];
        assign sum_w[g] = MAX_ACC'(total);
    end

    always_comb begin
        unique case (shift)
            2'd0:    sum = sum_w[0];
            2'd1:    sum = sum_w[1];
            default: sum = sum_w[2];
        endcase
    end

endmodule

// File: rtl/wmac_classify.sv
module wmac_classify
    import wmac_pkg::*;
#(
    parameter int VLEN = 64
) (
    input  logic [$clog2(VLEN/8)-1:0] idx,
    input  logic [$clog2(VLEN/8):0]   first,
    input  logic [$clog2(VLEN/8):0]   len,
    input  logic                      unmasked,
    input  logic                      en_bit,
    output elem_class_e               cls
);

    localparam int CNTW = $clog2(VLEN/8) + 1;

    logic [CNTW-1:0] idx_w;
    logic            below_first;
    logic            past_len;
    logic            gated_off;

    assign idx_w       = {1'b0, idx};
    assign below_first = idx_w < first;
    assign past_len    = idx_w >= len;
    assign gated_off   = !unmasked && !en_bit;

    // Prestart outranks tail, tail outranks mask.
    always_comb begin
        if (below_first)    cls = CLS_PRESTART;
        else if (past_len)  cls = CLS_TAIL;
        else if (gated_off) cls = CLS_MASKOFF;
        else                cls = CLS_ACTIVE;
    end

endmodule

// File: rtl/wmac_writeback.sv
module wmac_writeback
    import wmac_pkg::*;
#(
    parameter int VLEN = 64
) (
    input  logic [2*VLEN-1:0]         acc_cur,
    input  logic [$clog2(VLEN/8)-1:0] idx,
    input  logic [1:0]                shift,
    input  elem_class_e               cls,
    input  logic [MAX_ACC-1:0]        sum,
    input  logic [MAX_ACC-1:0]        old_elem,
    input  logic                      tail_agn,
    input  logic                      mask_agn,
    output logic [2*VLEN-1:0]         acc_next
);

    localparam int NW = 3;
    localparam int DW = 2 * VLEN;

    logic [MAX_ACC-1:0] value;
    logic [DW-1:0]      next_w [NW];

    always_comb begin
        unique case (cls)
            CLS_ACTIVE:   value = sum;
            CLS_TAIL:     value = tail_agn ? '1 : old_elem;
            CLS_MASKOFF:  value = mask_agn ? '1 : old_elem;
            default:      value = old_elem;
        endcase
    end

    // Lane insertion for each element width.
    for (genvar g = 0; g < NW; g++) begin : g_width
        localparam int W2 = 2 * (8 << g);
        logic [DW-1:0] lane_mask;
        logic [DW-1:0] lane_val;

        assign lane_mask = DW'({W2{1'b1}}) << (idx * W2);
        assign lane_val  = DW'(value[W2-1:0]) << (idx * W2);
        assign next_w[g] = (acc_cur & ~lane_mask) | lane_val;
    end

    always_comb begin
        unique case (shift)
            2'd0:    acc_next = next_w[0];
            2'd1:    acc_next = next_w[1];
            default: acc_next = next_w[2];
        endcase
    end

endmodule

// File: rtl/wmac_unit.sv
module wmac_unit
    import wmac_pkg::*;
#(
    parameter int VLEN = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [1:0]                  width_sel,
    input  logic [$clog2(VLEN/8):0]     elem_len,
    input  logic [$clog2(VLEN/8):0]     start_idx,
    input  logic                        unmasked,
    input  logic [VLEN/8-1:0]           elem_en,
    input  logic                        tail_agn,
    input  logic                        mask_agn,
    input  logic [VLEN-1:0]             src_a,
    input  logic [VLEN-1:0]             src_b,
    input  logic [2*VLEN-1:0]           acc_in,
    output logic                        busy,
    output logic                        done,
    output logic [2*VLEN-1:0]           acc_out,
    output logic [$clog2(VLEN/8):0]     resume_idx
);

    localparam int MAXE = VLEN / 8;
    localparam int IDXW = $clog2(MAXE);
    localparam int CNTW = IDXW + 1;
    localparam int DW   = 2 * VLEN;

    state_e state_q, state_d;

    logic [1:0]        wsel_q;
    logic [CNTW-1:0]   len_q;
    logic [CNTW-1:0]   first_q;
    logic              unmasked_q;
    logic [MAXE-1:0]   en_q;
    logic              tagn_q;
    logic              magn_q;
    logic [VLEN-1:0]   a_q;
    logic [VLEN-1:0]   b_q;
    logic [DW-1:0]     acc_q;
    logic [IDXW-1:0]   idx_q;
    logic [CNTW-1:0]   resume_q;

    logic [1:0]          shift;
    logic [CNTW-1:0]     elem_max;
    logic                at_last;
    logic                accept;
    logic [MAX_SEW-1:0]  op_a;
    logic [MAX_SEW-1:0]  op_b;
    logic [MAX_ACC-1:0]  op_acc;
    logic [MAX_ACC-1:0]  sum;
    elem_class_e         cls;
    logic [DW-1:0]       acc_next;

    assign shift    = sew_shift(wsel_q);
    assign elem_max = CNTW'(MAXE >> shift);
    assign at_last  = ({1'b0, idx_q} == (elem_max - 1'b1));
    assign accept   = (state_q == ST_IDLE) && start;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: accept, step, finish, return.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)   state_d = ST_RUN;
            ST_RUN:  if (at_last) state_d = ST_DONE;
            ST_DONE:              state_d = ST_IDLE;
            default:              state_d = ST_IDLE;
        endcase
    end

    // Status outputs decoded from the state.
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN:  busy = 1'b1;
            ST_DONE: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: ;
        endcase
    end

    // Operand capture and per-element sequencing.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wsel_q     <= '0;
            len_q      <= '0;
            first_q    <= '0;
            unmasked_q <= 1'b0;
            en_q       <= '0;
            tagn_q     <= 1'b0;
            magn_q     <= 1'b0;
            a_q        <= '0;
            b_q        <= '0;
            acc_q      <= '0;
            idx_q      <= '0;
            resume_q   <= '0;
        end else if (accept) begin
            wsel_q     <= width_sel;
            len_q      <= elem_len;
            first_q    <= start_idx;
            unmasked_q <= unmasked;
            en_q       <= elem_en;
            tagn_q     <= tail_agn;
            magn_q     <= mask_agn;
            a_q        <= src_a;
            b_q        <= src_b;
            acc_q      <= acc_in;
            idx_q      <= '0;
            resume_q   <= start_idx;
        end else if (state_q == ST_RUN) begin
            acc_q <= acc_next;
            idx_q <= idx_q + 1'b1;
            if (at_last) resume_q <= '0;
        end
    end

    wmac_operand_sel #(.VLEN(VLEN)) sel_i (
        .src_a  (a_q),
        .src_b  (b_q),
        .acc    (acc_q),
        .idx    (idx_q),
        .shift  (shift),
        .op_a   (op_a),
        .op_b   (op_b),
        .op_acc (op_acc)
    );

    wmac_mac mac_i (
        .op_a   (op_a),
        .op_b   (op_b),
        .op_acc (op_acc),
        .shift  (shift),
        .sum    (sum)
    );

    wmac_classify #(.VLEN(VLEN)) cls_i (
        .idx      (idx_q),
        .first    (first_q),
        .len      (len_q),
        .unmasked (unmasked_q),
        .en_bit   (en_q[idx_q]),
        .cls      (cls)
    );

    wmac_writeback #(.VLEN(VLEN)) wb_i (
        .acc_cur  (acc_q),
        .idx      (idx_q),
        .shift    (shift),
        .cls      (cls),
        .sum      (sum),
        .old_elem (op_acc),
        .tail_agn (tagn_q),
        .mask_agn (magn_q),
        .acc_next (acc_next)
    );

    assign acc_out    = acc_q;
    assign resume_idx = resume_q;

endmodule

// File: rtl/wmac_unit_chk.sv
module wmac_unit_chk
    import wmac_pkg::*;
#(
    parameter int VLEN = 64
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic [1:0]              width_sel,
    input logic                    busy,
    input logic                    done,
    input logic [2*VLEN-1:0]       acc_out,
    input logic [$clog2(VLEN/8):0] resume_idx
);

    localparam int MAXE = VLEN / 8;
    localparam int CW   = $clog2(MAXE) + 3;

    logic [CW-1:0] run_cnt;
    logic [CW-1:0] run_len;

    // Cycle counter for the pass length window.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
            run_len <= '0;
        end else if (start && !busy) begin
            run_cnt <= '0;
            run_len <= CW'(MAXE >> sew_shift(width_sel));
        end else if (busy) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done)); // R7

    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == run_len)); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R7

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && !done) |=> busy); // R8

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(acc_out)); // R9

    AST_RESUME_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (resume_idx == '0)); // R9

endmodule

bind wmac_unit wmac_unit_chk #(.VLEN(VLEN)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .width_sel  (width_sel),
    .busy       (busy),
    .done       (done),
    .acc_out    (acc_out),
    .resume_idx (resume_idx)
);

// File: tb/wmac_unit_tb_top.sv
module wmac_unit_tb_top;

    localparam int VLEN = 64;
    localparam int MAXE = VLEN / 8;
    localparam int CNTW = $clog2(MAXE) + 1;
    localparam int DW   = 2 * VLEN;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [1:0]      width_sel = '0;
    logic [CNTW-1:0] elem_len = '0;
    logic [CNTW-1:0] start_idx = '0;
    logic            unmasked = 1'b0;
    logic [MAXE-1:0] elem_en = '0;
    logic            tail_agn = 1'b0;
    logic            mask_agn = 1'b0;
    logic [VLEN-1:0] src_a = '0;
    logic [VLEN-1:0] src_b = '0;
    logic [DW-1:0]   acc_in = '0;
    logic            busy;
    logic            done;
    logic [DW-1:0]   acc_out;
    logic [CNTW-1:0] resume_idx;

    int          checks = 0;
    int          fails = 0;
    bit          finished = 1'b0;
    logic [31:0] seed = 32'h2468_ace1;

    always #5 clk = ~clk;

    wmac_unit #(.VLEN(VLEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .width_sel(width_sel),
        .elem_len(elem_len), .start_idx(start_idx), .unmasked(unmasked),
        .elem_en(elem_en), .tail_agn(tail_agn), .mask_agn(mask_agn),
        .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
        .busy(busy), .done(done), .acc_out(acc_out), .resume_idx(resume_idx)
    );

    function automatic logic [31:0] rnd32();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Arithmetic reference for a whole pass.
    function automatic logic [DW-1:0] model(input int sh, input int len, input int first,
                                            input bit um, input logic [MAXE-1:0] en,
                                            input bit ta, input bit ma,
                                            input logic [VLEN-1:0] a, input logic [VLEN-1:0] b,
                                            input logic [DW-1:0] acc);
        int w = 8 << sh;
        int n = MAXE >> sh;
        logic [63:0] m1 = (w == 32) ? 64'hffff_ffff : ((64'd1 << w) - 64'd1);
        logic [63:0] m2 = (w == 32) ? '1 : ((64'd1 << (2 * w)) - 64'd1);
        logic [DW-1:0] res = acc;
        for (int i = 0; i < n; i++) begin
            logic [63:0] old = 64'(acc >> (i * 2 * w)) & m2;
            logic [63:0] va  = 64'(a >> (i * w)) & m1;
            logic [63:0] vb  = 64'(b >> (i * w)) & m1;
            logic [63:0] v   = old;
            if (i < first)                 v = old;
            else if (i >= len)             v = ta ? m2 : old;
            else if (!um && !en[i])        v = ma ? m2 : old;
            else                           v = (va * vb + old) & m2;
            res = (res & ~(DW'(m2) << (i * 2 * w))) | (DW'(v) << (i * 2 * w));
        end
        return res;
    endfunction

    function automatic string tag_of(input int i, input int len, input int first,
                                     input bit um, input logic [MAXE-1:0] en);
        if (i < first)           return "R4 prestart";
        if (i >= len)            return "R5 tail";
        if (!um && !en[i])       return "R6 masked-off";
        if (um && !en[i])        return "R3 unmasked";
        return "R1 active";
    endfunction

    task automatic run_op(input int code, input int len, input int first, input bit um,
                          input bit ta, input bit ma, input bit inject, input bit force_max);
        int sh = (code == 3) ? 2 : code;
        int w  = 8 << sh;
        int n  = MAXE >> sh;
        logic [VLEN-1:0] a   = {rnd32(), rnd32()};
        logic [VLEN-1:0] b   = {rnd32(), rnd32()};
        logic [DW-1:0]   acc = {rnd32(), rnd32(), rnd32(), rnd32()};
        logic [MAXE-1:0] en  = rnd32()[MAXE-1:0];
        logic [DW-1:0]   exp;
        logic [63:0]     m2  = (w == 32) ? '1 : ((64'd1 << (2 * w)) - 64'd1);
        bit              early = 1'b0;
        if (force_max) begin
            a = '1;
            b = '1;
            acc = '1;
        end
        exp = model(sh, len, first, um, en, ta, ma, a, b, acc);

        @(negedge clk);
        width_sel = 2'(code); elem_len = CNTW'(len); start_idx = CNTW'(first);
        unmasked = um; elem_en = en; tail_agn = ta; mask_agn = ma;
        src_a = a; src_b = b; acc_in = acc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R7 busy after accept", DW'({busy, done}), DW'(2'b10));

        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            if (k == 2) begin
                start = 1'b0;
                src_a = a;
            end
            if (k < n && done) early = 1'b1;
            if (inject && k == 1) begin
                start = 1'b1;
                src_a = ~a;
            end
        end
        chk("R7 done timing", DW'({done, early}), DW'(2'b10));
        chk("R9 resume index at done", DW'(resume_idx), '0);
        for (int i = 0; i < n; i++) begin
            chk($sformatf("%s lane %0d sew %0d (R2)", tag_of(i, len, first, um, en), i, w),
                DW'(64'(acc_out >> (i * 2 * w)) & m2),
                DW'(64'(exp >> (i * 2 * w)) & m2));
        end
        if (inject) chk("R8 start ignored mid-pass", acc_out, exp);

        if (inject) begin
            start = 1'b1;
            src_a = ~a;
        end
        @(negedge clk);
        start = 1'b0;
        src_a = a;
        chk(inject ? "R8 start in done ignored" : "R7 idle after done",
            DW'({busy, done}), DW'(2'b00));
        @(negedge clk);
        @(negedge clk);
        chk("R9 result held", acc_out, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int runs = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset outputs", DW'({busy, done, resume_idx}), '0);
        chk("R10 reset accumulator", acc_out, '0);

        // R2 sweep over every width code, length, start index, mask mode and policy pair.
        for (int code = 0; code < 4; code++) begin
            int n = MAXE >> ((code == 3) ? 2 : code);
            for (int len = 0; len <= n + 1; len++) begin
                for (int first = 0; first <= n; first++) begin
                    for (int um = 0; um < 2; um++) begin
                        for (int pol = 0; pol < 4; pol++) begin
                            run_op(code, len, first, um[0], pol[0], pol[1],
                                   (runs % 5) == 1, (runs % 7) == 3);
                            runs++;
                        end
                    end
                end
            end
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule